// File: doc/BRIEF.md
# Network Controller Interrupt Status Aggregator

This block collects single-cycle event pulses from a network controller's receive and transmit paths into a small pending-status register. It drives one level-sensitive interrupt line toward the host. Each pending bit latches on its own event and stays set until software takes it. A per-source enable register and a single global enable bit together decide whether any pending bit raises the interrupt line.

Software reaches the pending bits through two addresses. The take address returns the pending bits and clears them in the same access. The peek address returns them untouched. A write to the peek address ORs the written mask into the pending bits, so software can retrigger an event (for example, re-arm a receive event that it left unserviced). The host side is a plain read/write strobe interface. Read data comes back one cycle after the read strobe, with a valid flag.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the pending bits, the source enables and the global enable are all zero, irqOut is low, busRvalid is low and busRdata is zero.
- R2: A high evtPulse[i] sets pending bit i whether or not source i is enabled. The receive event uses bit 2 and the transmit event uses bit 3; bits 0 and 1 are the further receive-related sources.
- R3: A read of address 2 (take) returns the pending bits in busRdata[3:0], with all other bits zero, and busRvalid high in the cycle after the strobe. It clears those pending bits. A returned zero means nothing was pending.
- R4: A write to address 1 (set alias) ORs busWdata[3:0] into the pending bits. Pending bits whose written bit is zero are unchanged.
- R5: irqOut is high exactly when the global enable is set and at least one pending bit has its enable bit set. It follows a register change in the same cycle, with no extra register stage.
- R6: The source enable register is at address 0, in bits 3:0: bits 2:0 enable the receive-related sources and bit 3 enables transmit. It reads back as written.
- R7: An event arriving in the same cycle as a take read is absent from that read's data but remains pending for the next read.
- R8: A read of address 1 (peek) returns the pending bits without clearing them.
- R9: A write to address 2 leaves the pending bits unchanged. The global control at address 3 stores only bit 15, which is the global enable; it reads back with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | ADDR_W (3) | Register word address |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, valid with busRvalid |
| busRvalid | output | 1 | High one cycle after a read strobe |
| evtPulse | input | SRC_N (4) | Event pulses, one per source |
| irqOut | output | 1 | Level interrupt request |

## Verification
The bench attacks the event that lands in the same cycle as a take read. A design that lets the clear win drops that event, and a later read returns zero instead of the receive bit. It checks that a peek read leaves the pending bits as they were; a design that treats both aliases as clearing loses the second peek. It checks that writes to the take address leave the pending bits alone and that the global enable gates an otherwise active source; a wrong decode either wipes pending state or raises irqOut while globally masked. It also checks that a set-alias write retriggers the interrupt and that events latch while their source is disabled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // strobes from the bus decode to the state path
  typedef struct packed {
    logic enWr;    // source enable write
    logic globWr;  // global control write
    logic setWr;   // set-alias write
    logic enRd;    // source enable read
    logic globRd;  // global control read
    logic peekRd;  // pending read, no clear
    logic takeRd;  // pending read with clear
    logic anyRd;   // any read strobe
  } ctlStrobe_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int ENA_ADR  = 0,
  parameter int PEEK_ADR = 1,
  parameter int TAKE_ADR = 2,
  parameter int GLOB_ADR = 3
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] EnaA  = ADDR_W'(ENA_ADR);
  localparam logic [ADDR_W-1:0] PeekA = ADDR_W'(PEEK_ADR);
  localparam logic [ADDR_W-1:0] TakeA = ADDR_W'(TAKE_ADR);
  localparam logic [ADDR_W-1:0] GlobA = ADDR_W'(GLOB_ADR);

  always_comb begin
    strb        = '0;
    strb.anyRd  = busRd;
    strb.enWr   = busWr && (busAddr == EnaA);
    strb.setWr  = busWr && (busAddr == PeekA);
    strb.globWr = busWr && (busAddr == GlobA);
    strb.enRd   = busRd && (busAddr == EnaA);
    strb.peekRd = busRd && (busAddr == PeekA);
    strb.takeRd = busRd && (busAddr == TakeA);
    strb.globRd = busRd && (busAddr == GlobA);
  end
endmodule

// File: rtl/irq_state_path.sv
module irq_state_path
  import irq_agg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SRC_N    = 4,
  parameter int GLOB_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [SRC_N-1:0]  evtPulse,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              irqOut
);
  localparam int PadW = DATA_W - SRC_N;

  logic [SRC_N-1:0]  pend;
  logic [SRC_N-1:0]  srcEn;
  logic              globEn;
  logic [DATA_W-1:0] rdNext;

  // one flop per source: event and set win over the take clear
  for (genvar i = 0; i < SRC_N; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)
        pend[i] <= 1'b0;
      else
        pend[i] <= (pend[i] & ~strb.takeRd) | evtPulse[i] | (strb.setWr & busWdata[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcEn  <= '0;
      globEn <= 1'b0;
    end else begin
      if (strb.enWr)   srcEn  <= busWdata[SRC_N-1:0];
      if (strb.globWr) globEn <= busWdata[GLOB_BIT];
    end
  end

  always_comb begin
    rdNext = '0;
    if (strb.enRd)                   rdNext = {{PadW{1'b0}}, srcEn};
    if (strb.peekRd || strb.takeRd)  rdNext = {{PadW{1'b0}}, pend};
    if (strb.globRd)                 rdNext[GLOB_BIT] = globEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= strb.anyRd;
      if (strb.anyRd) busRdata <= rdNext;
    end
  end

  assign irqOut = globEn & (|(pend & srcEn));

  // R2: an event is pending in the following cycle
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((pend & $past(evtPulse)) == $past(evtPulse)));

  // R3: a take read with no concurrent set or event leaves nothing pending
  p_take_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeRd && !strb.setWr && evtPulse == '0) |=> (pend == '0));

  // R3: take data is the pre-clear pending value
  p_take_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeRd |=> (busRvalid && busRdata[SRC_N-1:0] == $past(pend)));

  // R4: set-alias bits are pending afterwards
  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.setWr |=> ((pend & $past(busWdata[SRC_N-1:0])) == $past(busWdata[SRC_N-1:0])));

  // R5: clearing the global enable silences the output
  p_glob_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.globWr && !busWdata[GLOB_BIT]) |=> !irqOut);

  // R8: a peek read keeps every pending bit
  p_peek_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.peekRd && !strb.takeRd) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int SRC_N    = 4,
  parameter int GLOB_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic [SRC_N-1:0]  evtPulse,
  output logic              irqOut
);
  ctlStrobe_t strb;

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .busRd  (busRd),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irq_state_path #(.DATA_W(DATA_W), .SRC_N(SRC_N), .GLOB_BIT(GLOB_BIT)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .evtPulse (evtPulse),
    .busRdata (busRdata),
    .busRvalid(busRvalid),
    .irqOut   (irqOut)
  );

  // R1: a read always answers in the next cycle, and only then
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rstN)
    busRvalid == $past(busRd));
endmodule

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic [3:0]  evtPulse = '0;
  logic        irqOut;

  int nVec = 0, nBad = 0;
  bit done = 0;

  logic [3:0] mPend = '0, mEn = '0;
  logic       mGlob = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irq_status_agg u0 (.clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .evtPulse(evtPulse), .irqOut(irqOut));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, mEn};
      3'd1, 3'd2: return {28'd0, mPend};
      3'd3: return {16'd0, mGlob, 15'd0};
      default: return 32'd0;
    endcase
  endfunction

  // read with an optional event in the same cycle
  task automatic busRead(input logic [2:0] a, input logic [3:0] evt, input string tag);
    expQ.push_back(modelRead(a));
    tagQ.push_back(tag);
    busRd = 1'b1; busAddr = a; evtPulse = evt;
    if (a == 3'd2) mPend = '0;
    mPend |= evt;
    @(negedge clk);
    busRd = 1'b0; evtPulse = '0;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    case (a)
      3'd0: mEn = d[3:0];
      3'd1: mPend |= d[3:0];
      3'd3: mGlob = d[15];
      default: ;
    endcase
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] evt);
    evtPulse = evt; mPend |= evt;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic chkIrq(input string tag);
    chk({31'd0, irqOut}, {31'd0, mGlob & (|(mPend & mEn))}, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && busRvalid) begin
      if (expQ.size() == 0) begin
        nVec++; nBad++;
        $display("FAIL R3 unexpected read data act=%h exp=none", busRdata);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(busRdata, e, t);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({31'd0, irqOut}, 32'd0, "R1 irq in reset");
    chk(busRdata, 32'd0, "R1 rdata in reset");
    chk({31'd0, busRvalid}, 32'd0, "R1 rvalid in reset");
    rstN = 1'b1;
    @(negedge clk);
    busRead(3'd0, 4'h0, "R1 enable reset");
    busRead(3'd2, 4'h0, "R1 R3 take empty");
    busRead(3'd3, 4'h0, "R1 global reset");
    chkIrq("R1 irq idle");

    pulse(4'h4);                          // rx event, disabled
    busRead(3'd1, 4'h0, "R2 R8 peek rx");
    busRead(3'd1, 4'h0, "R8 peek again");
    chkIrq("R2 no irq while disabled");

    busWrite(3'd0, 32'h0000_0004);
    chkIrq("R5 global off");
    busWrite(3'd3, 32'h0000_8000);
    chkIrq("R5 irq up");
    chk({31'd0, irqOut}, 32'd1, "R5 irq literal");
    busRead(3'd3, 4'h0, "R9 global read");
    busWrite(3'd3, 32'hFFFF_7FFF);
    busRead(3'd3, 4'h0, "R9 only bit 15");
    chkIrq("R5 R9 masked");
    busWrite(3'd3, 32'h0000_8000);

    busRead(3'd2, 4'h0, "R3 take rx");
    chkIrq("R3 irq drops");
    busRead(3'd2, 4'h0, "R3 take after clear");

    pulse(4'h8);                          // tx event
    chkIrq("R6 tx not enabled");
    busWrite(3'd0, 32'hFFFF_FFFF);
    busRead(3'd0, 4'h0, "R6 enable readback");
    chkIrq("R6 tx irq");

    busRead(3'd2, 4'h4, "R7 take with rx event");
    busRead(3'd1, 4'h0, "R7 rx survives");
    chkIrq("R7 irq kept");

    busWrite(3'd2, 32'h0000_000F);
    busRead(3'd1, 4'h0, "R9 write to take ignored");

    busWrite(3'd1, 32'h0000_0003);
    busRead(3'd1, 4'h0, "R4 set alias");
    busRead(3'd2, 4'h0, "R4 take set bits");
    chkIrq("R4 irq cleared");
    busWrite(3'd1, 32'h0000_0004);
    chkIrq("R4 R5 retrigger");
    busRead(3'd2, 4'h0, "R4 take retrigger");

    pulse(4'h1); pulse(4'h2);
    busRead(3'd1, 4'h3, "R2 low sources");
    busRead(3'd2, 4'h0, "R2 take all");
    chkIrq("R5 final");

    repeat (3) @(negedge clk);
    chk(expQ.size(), 32'd0, "R3 all reads answered");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule